// File: doc/BRIEF.md
# Programmable I2C Bit-Rate Divider with Best-Fit Search

This block derives the I2C bit timing from the system clock through three cascaded divide stages. The first stage prescales by 2·(T+1) clocks, where T is an 8-bit half-period setting. The second stage divides by 2^E, with E a 3-bit exponent. The third stage divides by (D+1), with D a 4-bit factor. The third stage emits an oversample tick, and every tenth oversample tick is an SCL-rate tick. The resulting bit rate is f_sys / (2·(T+1)) / 2^E / (D+1) / 10.

A built-in search engine chooses the settings. When a start strobe is given, it latches the system and target frequencies. It then walks the (E, D) grid and, for each pair, computes a base half-period from one integer division. It tries that base value and the value one above it, and keeps the candidate whose achieved rate is nearest the target. The search shares a single sequential divider, evaluating one candidate per division. When it finishes, it publishes T and a packed control byte and pulses done. The divide chain restarts on the new settings in the same cycle.

Top module: `scl_rate_gen`

## Requirements
- R1: After reset, thp reads 0x18, clkCtl reads 0x10 and done is low.
- R2: ovsTick is a one-cycle pulse that repeats every 2·(T+1)·2^E·(D+1) clocks, where T is thp, D is clkCtl[6:3] and E is clkCtl[2:0].
- R3: sclTick is a one-cycle pulse that repeats every 10 oversample periods and coincides with an ovsTick.
- R4: For each pair (E, D), the search takes q = floor(f_sys / (2·f_tgt·(D+1)·10·2^E)). It tries T = q−1 and T = q. For each T it computes the achieved rate floor(f_sys / (2·(T+1)·2^E·(D+1)·10)) and takes the absolute error against f_tgt.
- R5: Only T in 5..255 is tried. E covers 0..7 and D covers 2..15, so every published result has thp ≥ 5 and clkCtl[6:3] ≥ 2.
- R6: The scan order is E ascending (outer loop), then D descending from 15 (inner loop), then T = q−1 before T = q. A candidate replaces the kept one only when its error is strictly smaller, so on a tie the earlier candidate stays.
- R7: Once the kept error is zero, the search ends at the close of the current (E, D) pair. An exact hit in the first pair completes within 200 clocks of start.
- R8: The kept error starts at 1,000,000. If no candidate beats it, the result is T = 0x18, D = 2, E = 0.
- R9: clkCtl packs the result as bit 7 = 0, bits 6:3 = D and bits 2:0 = E.
- R10: Each accepted start produces exactly one single-cycle done pulse. thp and clkCtl change only in the done cycle. The frequencies are latched at start, and start pulses or frequency changes during a search have no effect on it.
- R11: The divide chain restarts in the done cycle. The first ovsTick follows the done cycle by one oversample period minus one clock, and the first sclTick follows it by ten oversample periods minus one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a best-fit search (accepted only when idle) |
| fSys | input | 32 | System clock frequency in Hz |
| fTgt | input | 32 | Target SCL frequency in Hz |
| thp | output | 8 | Half-period prescale setting T |
| clkCtl | output | 8 | Packed control byte {0, D, E} |
| done | output | 1 | One-cycle pulse when a search result is published |
| ovsTick | output | 1 | Oversample-rate tick |
| sclTick | output | 1 | SCL-rate tick |

## Verification
The hardest situation to reach from the ports is a start strobe that arrives during a running search together with changed frequencies. The outputs give no sign of the search in progress, so the only visible evidence is the result that is finally published. The stimulus launches a long, full-grid search and then, about 500 clocks in, presents frequencies that would produce an early exact hit along with a second start. The scoreboard expects only the first search's result and exactly one done pulse.

The restart phase of the tick chain is checked by counting clocks from the done cycle to the first oversample and SCL ticks.

// File: rtl/scl_rate_pkg.sv
package scl_rate_pkg;

  localparam int THP_LO  = 5;
  localparam int THP_HI  = 255;
  localparam int DIVM_LO = 2;
  localparam int DIVM_HI = 15;
  localparam int EXP_HI  = 7;
  localparam int OVS_DIV = 10;

  localparam logic [7:0] THP_DEF  = 8'h18;
  localparam logic [3:0] DIVM_DEF = 4'd2;
  localparam logic [2:0] EXP_DEF  = 3'd0;

  // strobes from the search sequencer to the datapath
  typedef struct packed {
    logic init;       // latch frequencies, reset best and loop indices
    logic baseGo;     // start base half-period division
    logic baseLatch;  // capture base quotient
    logic candGo;     // start candidate rate division
    logic candEval;   // compare candidate error to best
    logic incSet;     // move to second candidate of the pair
    logic pairStep;   // advance (exponent, factor) pair
    logic finish;     // publish result
  } ctlStrobe_t;

  // status returned by the datapath
  typedef struct packed {
    logic divDone;
    logic candLegal;
    logic incIsOne;
    logic errZero;
    logic lastPair;
  } searchStat_t;

endpackage

// File: rtl/scl_rate_div.sv
module scl_rate_div #(
  parameter int NUM_W = 32,
  parameter int DEN_W = 48
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [NUM_W-1:0] numIn,
  input  logic [DEN_W-1:0] denIn,
  output logic             busy,
  output logic             done,
  output logic [NUM_W-1:0] quo
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [DEN_W-1:0] remR;
  logic [DEN_W-1:0] denR;
  logic [NUM_W-1:0] quoR;
  logic [CNT_W-1:0] cntR;
  logic             busyR;
  logic             doneR;
  logic [DEN_W:0]   trial;
  logic             fits;

  assign trial = {remR, quoR[NUM_W-1]};
  assign fits  = trial >= {1'b0, denR};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remR  <= '0;
      denR  <= '0;
      quoR  <= '0;
      cntR  <= '0;
      busyR <= 1'b0;
      doneR <= 1'b0;
    end else begin
      doneR <= 1'b0;
      if (start && !busyR) begin
        remR  <= '0;
        denR  <= denIn;
        quoR  <= numIn;
        cntR  <= CNT_W'(NUM_W);
        busyR <= 1'b1;
      end else if (busyR) begin
        remR <= fits ? DEN_W'(trial - {1'b0, denR}) : trial[DEN_W-1:0];
        quoR <= {quoR[NUM_W-2:0], fits};
        cntR <= cntR - CNT_W'(1);
        if (cntR == CNT_W'(1)) begin
          busyR <= 1'b0;
          doneR <= 1'b1;
        end
      end
    end
  end

  assign busy = busyR;
  assign done = doneR;
  assign quo  = quoR;

  // R4: a quotient is only reported at the end of a running division
  a_r4_done_after_busy: assert property (@(posedge clk) disable iff (!rstN)
    doneR |-> $past(busyR));

endmodule

// File: rtl/scl_rate_dp.sv
module scl_rate_dp
  import scl_rate_pkg::*;
#(
  parameter int FREQ_W   = 32,
  parameter int INIT_ERR = 1_000_000
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strb,
  input  logic [FREQ_W-1:0] fSys,
  input  logic [FREQ_W-1:0] fTgt,
  output searchStat_t       stat,
  output logic [7:0]        thpOut,
  output logic [7:0]        ctlOut,
  output logic              doneOut
);
  localparam int DEN_W = FREQ_W + 16;
  localparam int Q_W   = FREQ_W + 1;

  logic [FREQ_W-1:0] fSysR, fTgtR;
  logic [2:0]        expIdx;
  logic [3:0]        facIdx;
  logic              incR;
  logic [FREQ_W-1:0] baseQ;
  logic [7:0]        bestThp;
  logic [3:0]        bestFac;
  logic [2:0]        bestExp;
  logic [FREQ_W-1:0] bestErr;

  logic [8:0]        scale;
  logic [Q_W-1:0]    candQ;
  logic              candLegal;
  logic [DEN_W-1:0]  denBase, denCand, denSel;
  logic [FREQ_W-1:0] quo;
  logic              divBusy, divDone;
  logic [FREQ_W-1:0] diff;

  // (D+1) * 2 * 10 : both halves of the prescale and the oversample factor
  assign scale     = (9'(facIdx) + 9'd1) * 9'(2 * OVS_DIV);
  assign candQ     = Q_W'(baseQ) + Q_W'(incR);
  assign candLegal = (candQ >= Q_W'(THP_LO + 1)) && (candQ <= Q_W'(THP_HI + 1));
  assign denBase   = (DEN_W'(fTgtR) * DEN_W'(scale)) << expIdx;
  assign denCand   = (DEN_W'(candQ[8:0]) * DEN_W'(scale)) << expIdx;
  assign denSel    = strb.candGo ? denCand : denBase;

  scl_rate_div #(.NUM_W(FREQ_W), .DEN_W(DEN_W)) u_div (
    .clk   (clk),
    .rstN  (rstN),
    .start (strb.baseGo | strb.candGo),
    .numIn (fSysR),
    .denIn (denSel),
    .busy  (divBusy),
    .done  (divDone),
    .quo   (quo)
  );

  assign diff = (quo >= fTgtR) ? (quo - fTgtR) : (fTgtR - quo);

  assign stat.divDone   = divDone;
  assign stat.candLegal = candLegal;
  assign stat.incIsOne  = incR;
  assign stat.errZero   = (bestErr == '0);
  assign stat.lastPair  = (expIdx == 3'(EXP_HI)) && (facIdx == 4'(DIVM_LO));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fSysR   <= '0;
      fTgtR   <= '0;
      expIdx  <= '0;
      facIdx  <= 4'(DIVM_HI);
      incR    <= 1'b0;
      baseQ   <= '0;
      bestThp <= THP_DEF;
      bestFac <= DIVM_DEF;
      bestExp <= EXP_DEF;
      bestErr <= FREQ_W'(INIT_ERR);
      thpOut  <= THP_DEF;
      ctlOut  <= {1'b0, DIVM_DEF, EXP_DEF};
      doneOut <= 1'b0;
    end else begin
      doneOut <= strb.finish;
      if (strb.init) begin
        fSysR   <= fSys;
        fTgtR   <= fTgt;
        expIdx  <= '0;
        facIdx  <= 4'(DIVM_HI);
        incR    <= 1'b0;
        bestThp <= THP_DEF;
        bestFac <= DIVM_DEF;
        bestExp <= EXP_DEF;
        bestErr <= FREQ_W'(INIT_ERR);
      end
      if (strb.baseLatch) begin
        baseQ <= quo;
        incR  <= 1'b0;
      end
      if (strb.incSet) incR <= 1'b1;
      if (strb.candEval && (diff < bestErr)) begin
        bestErr <= diff;
        bestThp <= 8'(candQ - Q_W'(1));
        bestFac <= facIdx;
        bestExp <= expIdx;
      end
      if (strb.pairStep) begin
        if (facIdx == 4'(DIVM_LO)) begin
          facIdx <= 4'(DIVM_HI);
          expIdx <= expIdx + 3'd1;
        end else begin
          facIdx <= facIdx - 4'd1;
        end
      end
      if (strb.finish) begin
        thpOut <= bestThp;
        ctlOut <= {1'b0, bestFac, bestExp};
      end
    end
  end

  // R5: published settings stay inside the legal ranges
  a_r5_result_legal: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> (thpOut >= 8'(THP_LO)) && (ctlOut[6:3] >= 4'(DIVM_LO)));

  // R10: done is a single-cycle pulse
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut);

  // R10: settings move only together with done
  a_r10_outputs_hold: assert property (@(posedge clk) disable iff (!rstN)
    !doneOut |-> ($stable(thpOut) && $stable(ctlOut)));

endmodule

// File: rtl/scl_rate_ctrl.sv
module scl_rate_ctrl
  import scl_rate_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  searchStat_t stat,
  output ctlStrobe_t  strb
);
  typedef enum logic [2:0] {
    S_IDLE, S_BASE, S_BWAIT, S_CHECK, S_CWAIT, S_INC, S_NEXT
  } seqState_t;

  seqState_t state, nxt;

  always_comb begin
    strb = '0;
    nxt  = state;
    case (state)
      S_IDLE: if (start) begin
        strb.init = 1'b1;
        nxt = S_BASE;
      end
      S_BASE: begin
        strb.baseGo = 1'b1;
        nxt = S_BWAIT;
      end
      S_BWAIT: if (stat.divDone) begin
        strb.baseLatch = 1'b1;
        nxt = S_CHECK;
      end
      S_CHECK: if (stat.candLegal) begin
        strb.candGo = 1'b1;
        nxt = S_CWAIT;
      end else begin
        nxt = S_INC;
      end
      S_CWAIT: if (stat.divDone) begin
        strb.candEval = 1'b1;
        nxt = S_INC;
      end
      S_INC: if (!stat.incIsOne) begin
        strb.incSet = 1'b1;
        nxt = S_CHECK;
      end else begin
        nxt = S_NEXT;
      end
      S_NEXT: if (stat.errZero || stat.lastPair) begin
        strb.finish = 1'b1;
        nxt = S_IDLE;
      end else begin
        strb.pairStep = 1'b1;
        nxt = S_BASE;
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nxt;
  end

  // R7: the search ends only on an exact hit or after the last pair
  a_r7_finish_cause: assert property (@(posedge clk) disable iff (!rstN)
    strb.finish |-> (stat.errZero || stat.lastPair));

endmodule

// File: rtl/scl_tick_gen.sv
module scl_tick_gen #(
  parameter int THP_W = 8,
  parameter int EXP_W = 3,
  parameter int FAC_W = 4,
  parameter int OVS   = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             restart,
  input  logic [THP_W-1:0] thp,
  input  logic [EXP_W-1:0] expSel,
  input  logic [FAC_W-1:0] facSel,
  output logic             ovsTick,
  output logic             sclTick
);
  localparam int MASK_W = (1 << EXP_W) - 1;
  localparam int OVS_W  = $clog2(OVS);

  logic [THP_W:0]    halfCnt;
  logic [MASK_W-1:0] expCnt;
  logic [FAC_W-1:0]  facCnt;
  logic [OVS_W-1:0]  ovsCnt;
  logic [THP_W:0]    halfLast;
  logic [MASK_W-1:0] expMask;
  logic              tHalf, tExp, tFac, tScl;

  assign halfLast = {thp, 1'b1};  // 2*(T+1)-1
  assign expMask  = MASK_W'((MASK_W + 1)'(1) << expSel) - MASK_W'(1);
  assign tHalf    = (halfCnt == halfLast);
  assign tExp     = tHalf && (expCnt == expMask);
  assign tFac     = tExp && (facCnt == facSel);
  assign tScl     = tFac && (ovsCnt == OVS_W'(OVS - 1));

  always_ff @(posedge clk) begin
    if (!rstN || restart) begin
      halfCnt <= '0;
      expCnt  <= '0;
      facCnt  <= '0;
      ovsCnt  <= '0;
    end else begin
      halfCnt <= tHalf ? '0 : halfCnt + 1'b1;
      if (tHalf) expCnt <= tExp ? '0 : expCnt + 1'b1;
      if (tExp)  facCnt <= tFac ? '0 : facCnt + 1'b1;
      if (tFac)  ovsCnt <= tScl ? '0 : ovsCnt + 1'b1;
    end
  end

  assign ovsTick = tFac;
  assign sclTick = tScl;

  // R2: oversample ticks are isolated pulses (minimum period well above one)
  a_r2_ovs_spacing: assert property (@(posedge clk) disable iff (!rstN)
    ovsTick |=> !ovsTick);

  // R11: a restart is never followed directly by an oversample tick
  a_r11_quiet_after_restart: assert property (@(posedge clk) disable iff (!rstN)
    restart |=> !ovsTick);

endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen
  import scl_rate_pkg::*;
#(
  parameter int FREQ_W   = 32,
  parameter int INIT_ERR = 1_000_000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [FREQ_W-1:0] fSys,
  input  logic [FREQ_W-1:0] fTgt,
  output logic [7:0]        thp,
  output logic [7:0]        clkCtl,
  output logic              done,
  output logic              ovsTick,
  output logic              sclTick
);
  ctlStrobe_t  strb;
  searchStat_t stat;

  scl_rate_ctrl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .stat  (stat),
    .strb  (strb)
  );

  scl_rate_dp #(.FREQ_W(FREQ_W), .INIT_ERR(INIT_ERR)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .fSys    (fSys),
    .fTgt    (fTgt),
    .stat    (stat),
    .thpOut  (thp),
    .ctlOut  (clkCtl),
    .doneOut (done)
  );

  scl_tick_gen #(.THP_W(8), .EXP_W(3), .FAC_W(4), .OVS(OVS_DIV)) u_tick (
    .clk     (clk),
    .rstN    (rstN),
    .restart (strb.finish),
    .thp     (thp),
    .expSel  (clkCtl[2:0]),
    .facSel  (clkCtl[6:3]),
    .ovsTick (ovsTick),
    .sclTick (sclTick)
  );

endmodule

// File: tb/sim_scl_rate_gen.sv
module sim_scl_rate_gen;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] fSys = '0;
  logic [31:0] fTgt = '0;
  logic [7:0]  thp, clkCtl;
  logic        done, ovsTick, sclTick;

  scl_rate_gen u0 (
    .clk(clk), .rstN(rstN), .start(start), .fSys(fSys), .fTgt(fTgt),
    .thp(thp), .clkCtl(clkCtl), .done(done), .ovsTick(ovsTick), .sclTick(sclTick)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc++;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 0;
  logic [15:0] expQ[$];
  string       tagQ[$];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // best-fit model written from the requirements (R4, R5, R6, R7, R8, R9)
  function automatic logic [15:0] refSearch(input longint fs, input longint ft);
    longint best = 1000000;
    int bT = 24, bM = 2, bN = 0;
    for (int n = 0; n < 8 && best != 0; n++) begin
      for (int m = 15; m >= 2 && best != 0; m--) begin
        longint tclk = ft * (m + 1) * 10 * (64'd1 << n);
        longint base = fs / (tclk * 2) - 1;
        for (int inc = 0; inc < 2; inc++) begin
          longint t = base + inc;
          if (t >= 5 && t <= 255) begin
            longint fo;
            longint d;
            fo = fs / (2 * (t + 1));
            fo = fo / (64'd1 << n);
            fo = fo / (m + 1) / 10;
            d  = (fo > ft) ? fo - ft : ft - fo;
            if (d < best) begin
              best = d; bT = int'(t); bM = m; bN = n;
            end
          end
        end
      end
    end
    return {8'(bT), 1'b0, 4'(bM), 3'(bN)};
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin : mon
    logic [15:0] e;
    string       t;
    if (rstN && done) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R10", "unexpected done pulse", 1, 0);
      end else begin
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(thp == e[15:8], t, "thp", thp, e[15:8]);
        check(clkCtl == e[7:0], t, "clkCtl (R9 packing)", clkCtl, e[7:0]);
        check(thp >= 8'd5 && clkCtl[6:3] >= 4'd2 && !clkCtl[7], "R5",
              "result range", {thp, clkCtl}, e);
      end
    end
  end

  task automatic launch(input longint fs, input longint ft, input string tag);
    expQ.push_back(refSearch(fs, ft));
    tagQ.push_back(tag);
    @(negedge clk);
    fSys  = fs[31:0];
    fTgt  = ft[31:0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone();
    do @(negedge clk); while (!done);
  endtask

  task automatic measurePeriod(input bit useScl, input int expP, input string req);
    int t0;
    do @(negedge clk); while (!(useScl ? sclTick : ovsTick));
    t0 = cyc;
    do @(negedge clk); while (!(useScl ? sclTick : ovsTick));
    check(cyc - t0 == expP, req, useScl ? "scl period" : "ovs period", cyc - t0, expP);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run incomplete, got %0d cycles expected fewer", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    int startC, doneC, firstOvs;
    repeat (3) @(negedge clk);
    // R1 reset values
    check(thp == 8'h18, "R1", "thp at reset", thp, 8'h18);
    check(clkCtl == 8'h10, "R1", "clkCtl at reset", clkCtl, 8'h10);
    check(done == 1'b0, "R1", "done at reset", done, 0);
    rstN = 1'b1;

    // R2/R3 with default settings: 2*25*1*3 = 150, x10 = 1500
    measurePeriod(1'b0, 150, "R2");
    measurePeriod(1'b1, 1500, "R3");

    // R4 general search
    launch(100000000, 100000, "R4");
    waitDone();

    // R7 exact hit in first pair: T=9, D=15, E=0
    launch(3200000, 1000, "R7");
    startC = cyc;
    waitDone();
    doneC = cyc;
    check(doneC - startC < 200, "R7", "early stop latency", doneC - startC, 200);
    firstOvs = -1;
    do begin
      @(negedge clk);
      if (ovsTick && firstOvs < 0) firstOvs = cyc - doneC;
    end while (!sclTick);
    check(firstOvs == 319, "R11", "first ovsTick offset", firstOvs, 319);
    check(cyc - doneC == 3199, "R11", "first sclTick offset", cyc - doneC, 3199);
    measurePeriod(1'b0, 320, "R2");
    measurePeriod(1'b1, 3200, "R3");

    // R8 no legal candidate (too slow and too fast system clock)
    launch(1000, 100000, "R8");
    waitDone();
    launch(64'd4000000000, 1, "R8");
    waitDone();
    measurePeriod(1'b0, 150, "R2");

    // R6 strict improvement / scan order, R4 large error case
    launch(50000000, 400000, "R6");
    waitDone();
    launch(64'd4000000000, 10000000, "R4");
    waitDone();

    // R10: restart attempt with new frequencies during a search is ignored
    launch(27000000, 100000, "R10");
    repeat (500) @(negedge clk);
    fSys  = 32'd3200000;
    fTgt  = 32'd1000;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitDone();
    @(negedge clk);
    check(done == 1'b0, "R10", "done width", done, 0);
    repeat (300) @(negedge clk);
    check(expQ.size() == 0, "R10", "pending results", expQ.size(), 0);

    finished = 1;
    summary();
    $finish;
  end

endmodule